// File: doc/BRIEF.md
# DMA Request Multiplexer with Synchronization

This block sits between a set of peripheral request lines and the request inputs of a DMA controller. Each output channel picks one source from the peripheral inputs or from a small bank of request generators. The selection is fully dynamic, so software can remap any source to any channel while the system runs. The selected request reaches the channel with no register on the way.

A channel can also hold its requests behind a synchronization input. When a sync edge of the programmed polarity arrives, the channel opens and lets exactly N+1 requests through. It counts each request when that request deasserts, then closes again. If a further sync edge arrives while requests from the previous event are still outstanding, the channel raises a sticky overrun flag. Software clears that flag by writing 1 to it.

The request generators make requests without any peripheral. A generator fires on an edge of its selected trigger input or on a software write. It then emits N+1 request pulses, and each pulse stays high until its consumer acknowledges it. Configuration goes through a single-cycle write port. Reads come back combinationally.

Top module: `dmamux_sync`

## Requirements
- R1: Addresses 0..15 hold the channel configuration. The source select is bits [4:0]: values 0..20 pick peripheral inputs and 21..24 pick generators 0..3. Any larger value forwards no request. Bits [9:8] hold the sync polarity, bits [14:12] the sync input and bits [20:16] the count N. The other bits read back as 0.
- R2: The selected request appears on its channel output in the same cycle as its source changes, with no clock edge in between.
- R3: The sync polarity encoding is 00 = no sync, 01 = rising edge, 10 = falling edge and 11 = both edges. With 00 the channel forwards its source ungated and ignores its sync input.
- R4: With sync enabled, the channel blocks its requests until the selected edge arrives. It opens after the second rising clock edge that follows the sync input change. It then forwards N+1 requests, counting each one on its deassertion, and blocks again.
- R5: A sync edge that arrives while the channel still has requests outstanding sets that channel's bit in the overrun flags. The flags are read at address 20, with bit c for channel c.
- R6: Writing 1 to a bit at address 20 clears that overrun flag. Writing 0 to a bit leaves that flag unchanged.
- R7: Writing a channel's configuration closes its gate and discards any outstanding count. A later sync edge therefore does not count as an overrun.
- R8: Addresses 16..19 configure generators 0..3. The trigger select is bits [2:0], the trigger polarity (same encoding as R3) is bits [5:4] and the count N is bits [12:8]. Writing bit g at address 21 fires generator g. The generator then emits N+1 request pulses, and each pulse is held until its ack input is high at a clock edge. A fire while the generator is busy is ignored.
- R9: A generator also fires on the selected edge of its trigger input. Its request rises at the second clock edge after the trigger change. With polarity 00 the trigger input is ignored.
- R10: After reset all channel outputs, overrun flags and configuration registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| periph_req | input | 21 | Peripheral request lines |
| sync_in | input | 8 | Synchronization inputs |
| trig_in | input | 8 | Generator trigger inputs |
| gen_ack | input | 4 | Per-generator acknowledge from the consumer |
| ch_req | output | 16 | Request outputs to the DMA channels |
| sync_ovr | output | 16 | Sticky per-channel sync overrun flags |

## Verification
The assertions assume that the request, sync, trigger and acknowledge inputs are synchronous to the clock. They also assume that a request stays low for at least one clock edge between two requests, since a shorter gap would hide a deassertion from the counter. The stimulus changes every input only on the falling clock edge. It keeps each request high and low for at least one full cycle. It raises an acknowledge only while the matching generator request is visible on a channel. Configuration writes take one cycle each and never overlap the sync edge being tested.

// File: rtl/dmamux_sync.sv
`timescale 1ns/1ps
module dmamux_sync #(
  parameter int NUM_IN   = 21,
  parameter int NUM_CH   = 16,
  parameter int NUM_GEN  = 4,
  parameter int NUM_SYNC = 8,
  parameter int NUM_TRIG = 8,
  parameter int CNT_W    = 5,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_IN-1:0] periph_req,
  input  logic [NUM_SYNC-1:0] sync_in,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [NUM_GEN-1:0]  gen_ack,
  output logic [NUM_CH-1:0]   ch_req,
  output logic [NUM_CH-1:0]   sync_ovr
);
  localparam int NUM_SRC  = NUM_IN + NUM_GEN;
  localparam int SEL_W    = $clog2(NUM_SRC);
  localparam int SSEL_W   = $clog2(NUM_SYNC);
  localparam int TSEL_W   = $clog2(NUM_TRIG);
  localparam int GEN_BASE = NUM_CH;
  localparam int OVR_ADDR = NUM_CH + NUM_GEN;
  localparam int SWT_ADDR = OVR_ADDR + 1;
  localparam int F_SEL = 0, F_POL = 8, F_SSEL = 12, F_CNT = 16;
  localparam int G_TSEL = 0, G_POL = 4, G_CNT = 8;
  localparam logic [DATA_W-1:0] CH_MASK =
      (((DATA_W'(1) << SEL_W) - 1) << F_SEL) | (DATA_W'(3) << F_POL) |
      (((DATA_W'(1) << SSEL_W) - 1) << F_SSEL) | (((DATA_W'(1) << CNT_W) - 1) << F_CNT);
  localparam logic [DATA_W-1:0] GEN_MASK =
      (((DATA_W'(1) << TSEL_W) - 1) << G_TSEL) | (DATA_W'(3) << G_POL) |
      (((DATA_W'(1) << CNT_W) - 1) << G_CNT);
  localparam logic [CNT_W:0] ONE = 1;

  logic [NUM_SYNC-1:0] sync_q1, sync_q2;
  logic [NUM_TRIG-1:0] trig_q1, trig_q2;
  logic [NUM_GEN-1:0]  gen_req;
  logic [NUM_SRC-1:0]  src;
  logic [NUM_CH-1:0][DATA_W-1:0]  ch_word;
  logic [NUM_GEN-1:0][DATA_W-1:0] gen_word;
  logic [NUM_CH-1:0][CNT_W:0]     remain_all;
  logic [NUM_GEN-1:0][CNT_W:0]    gen_cnt_all;

  assign src = {gen_req, periph_req};

  function automatic logic edge_hit(input logic [1:0] pol, input logic cur, input logic prev);
    return (pol[0] & cur & ~prev) | (pol[1] & ~cur & prev);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q1 <= '0; sync_q2 <= '0; trig_q1 <= '0; trig_q2 <= '0;
    end else begin
      sync_q1 <= sync_in; sync_q2 <= sync_q1;
      trig_q1 <= trig_in; trig_q2 <= trig_q1;
    end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] cfg;
    logic [CNT_W:0]    rem;
    logic              req_q, ovr, hit, picked, open, cfg_wr;
    wire [SEL_W-1:0]  sel  = cfg[F_SEL +: SEL_W];
    wire [1:0]        pol  = cfg[F_POL +: 2];
    wire [SSEL_W-1:0] ssel = cfg[F_SSEL +: SSEL_W];
    wire [CNT_W-1:0]  n    = cfg[F_CNT +: CNT_W];

    assign cfg_wr = reg_wr && (reg_addr == ADDR_W'(c));
    assign hit    = edge_hit(pol, sync_q1[ssel], sync_q2[ssel]);
    assign picked = (sel < SEL_W'(NUM_SRC)) ? src[sel] : 1'b0;
    assign open   = (pol == 2'b00) || (rem != '0);
    assign ch_req[c]     = picked & open;
    assign sync_ovr[c]   = ovr;
    assign ch_word[c]    = cfg;
    assign remain_all[c] = rem;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cfg <= '0; rem <= '0; req_q <= 1'b0;
      end else if (cfg_wr) begin
        cfg <= reg_wdata & CH_MASK; rem <= '0; req_q <= 1'b0;
      end else begin
        req_q <= ch_req[c];
        if (hit) rem <= {1'b0, n} + ONE;
        else if (req_q && !ch_req[c] && rem != '0) rem <= rem - ONE;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ovr <= 1'b0;
      else if (!cfg_wr && hit && rem != '0) ovr <= 1'b1;
      else if (reg_wr && reg_addr == ADDR_W'(OVR_ADDR) && reg_wdata[c]) ovr <= 1'b0;
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic [DATA_W-1:0] cfg;
    logic [CNT_W:0]    cnt;
    logic              req, fire, gen_wr;
    wire [TSEL_W-1:0] tsel = cfg[G_TSEL +: TSEL_W];
    wire [CNT_W-1:0]  n    = cfg[G_CNT +: CNT_W];

    assign gen_wr = reg_wr && (reg_addr == ADDR_W'(GEN_BASE + g));
    assign fire   = edge_hit(cfg[G_POL +: 2], trig_q1[tsel], trig_q2[tsel]) ||
                    (reg_wr && reg_addr == ADDR_W'(SWT_ADDR) && reg_wdata[g]);
    assign gen_req[g]     = req;
    assign gen_word[g]    = cfg;
    assign gen_cnt_all[g] = cnt;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cfg <= '0; cnt <= '0; req <= 1'b0;
      end else if (gen_wr) begin
        cfg <= reg_wdata & GEN_MASK; cnt <= '0; req <= 1'b0;
      end else if (fire && cnt == '0) begin
        cnt <= {1'b0, n} + ONE; req <= 1'b1;
      end else if (req && gen_ack[g]) begin
        cnt <= cnt - ONE; req <= 1'b0;
      end else if (!req && cnt != '0) begin
        req <= 1'b1;
      end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = ch_word[i];
    for (int i = 0; i < NUM_GEN; i++)
      if (reg_addr == ADDR_W'(GEN_BASE + i)) reg_rdata = gen_word[i];
    if (reg_addr == ADDR_W'(OVR_ADDR)) reg_rdata = DATA_W'(sync_ovr);
  end
endmodule

// File: rtl/dmamux_sync_chk.sv
`timescale 1ns/1ps
module dmamux_sync_chk #(
  parameter int NUM_IN  = 21,
  parameter int NUM_CH  = 16,
  parameter int NUM_GEN = 4,
  parameter int CNT_W   = 5,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input logic clk,
  input logic rst_n,
  input logic reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [NUM_IN-1:0] periph_req,
  input logic [NUM_GEN-1:0] gen_ack,
  input logic [NUM_CH-1:0] ch_req,
  input logic [NUM_CH-1:0] sync_ovr,
  input logic [NUM_GEN-1:0] gen_req,
  input logic [NUM_CH-1:0][CNT_W:0] remain,
  input logic [NUM_GEN-1:0][CNT_W:0] gen_cnt
);
  localparam int GEN_BASE = NUM_CH;
  localparam int OVR_ADDR = NUM_CH + NUM_GEN;
  localparam logic [CNT_W:0] ONE = 1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    p_req_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ch_req[c] |-> ((periph_req != '0) || (gen_req != '0)));

    p_ovr_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_ovr[c]) |->
        $past(reg_wr && reg_addr == ADDR_W'(OVR_ADDR) && reg_wdata[c]));

    p_count_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((remain[c] + ONE == $past(remain[c])) && !$past(reg_wr)) |-> !$past(ch_req[c]));
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    p_gen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_req[g] && !gen_ack[g] && !(reg_wr && reg_addr == ADDR_W'(GEN_BASE + g)))
        |=> gen_req[g]);

    p_gen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gen_req[g] |-> (gen_cnt[g] != '0));
  end
endmodule

bind dmamux_sync dmamux_sync_chk #(
  .NUM_IN(NUM_IN), .NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN),
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .periph_req(periph_req), .gen_ack(gen_ack),
  .ch_req(ch_req), .sync_ovr(sync_ovr), .gen_req(gen_req),
  .remain(remain_all), .gen_cnt(gen_cnt_all)
);

// File: tb/dmamux_sync_tb_top.sv
`timescale 1ns/1ps
module dmamux_sync_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [20:0] periph_req = '0;
  logic [7:0]  sync_in = '0;
  logic [7:0]  trig_in = '0;
  logic [3:0]  gen_ack = '0;
  logic [15:0] ch_req;
  logic [15:0] sync_ovr;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dmamux_sync dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .sync_in(sync_in), .trig_in(trig_in), .gen_ack(gen_ack),
    .ch_req(ch_req), .sync_ovr(sync_ovr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] cfgw(input int sel, input int pol, input int ssel, input int n);
    return 32'(sel) | (32'(pol) << 8) | (32'(ssel) << 12) | (32'(n) << 16);
  endfunction

  function automatic logic [31:0] gcfg(input int tsel, input int pol, input int n);
    return 32'(tsel) | (32'(pol) << 4) | (32'(n) << 8);
  endfunction

  task automatic t_reset;
    chk("R10 ch_req after reset", 32'(ch_req), 32'h0);
    chk("R10 sync_ovr after reset", 32'(sync_ovr), 32'h0);
    reg_addr = 5'd0; #1;
    chk("R10 config after reset", reg_rdata, 32'h0);
  endtask

  task automatic t_route;
    wr(5'd3, cfgw(7, 0, 0, 0));
    wr(5'd5, cfgw(20, 0, 0, 0));
    periph_req[7] = 1'b1; #1;
    chk("R2 same-cycle forward ch3", 32'(ch_req[3]), 32'h1);
    chk("R1 ch5 not driven by input 7", 32'(ch_req[5]), 32'h0);
    periph_req[20] = 1'b1; #1;
    chk("R1 input 20 to ch5", 32'(ch_req[5]), 32'h1);
    periph_req[7] = 1'b0; #1;
    chk("R2 same-cycle release ch3", 32'(ch_req[3]), 32'h0);
    reg_addr = 5'd3; #1;
    chk("R1 readback ch3", reg_rdata, cfgw(7, 0, 0, 0));
    wr(5'd9, 32'hFFFF_FFFF);
    reg_addr = 5'd9; #1;
    chk("R1 unused bits read 0", reg_rdata, 32'h001F_731F);
    wr(5'd4, cfgw(30, 0, 0, 0));
    periph_req = '1; #1;
    chk("R1 out-of-range select", 32'(ch_req[4]), 32'h0);
    periph_req = '0;
    periph_req[7] = 1'b1;
    sync_in[0] = 1'b1; tick(3);
    chk("R3 polarity 00 ignores sync", 32'(ch_req[3]), 32'h1);
    periph_req = '0; sync_in = '0; tick(2);
  endtask

  task automatic t_sync_rise;
    wr(5'd2, cfgw(4, 1, 1, 1));
    periph_req[4] = 1'b1; #1;
    chk("R4 blocked before sync", 32'(ch_req[2]), 32'h0);
    tick(1);
    chk("R4 still blocked", 32'(ch_req[2]), 32'h0);
    periph_req[4] = 1'b0;
    sync_in[1] = 1'b1;
    tick(2);
    for (int k = 0; k < 2; k++) begin
      periph_req[4] = 1'b1; #1;
      chk("R4 request passes after rising sync", 32'(ch_req[2]), 32'h1);
      tick(1);
      periph_req[4] = 1'b0;
      tick(1);
    end
    periph_req[4] = 1'b1; #1;
    chk("R4 gate closed after N+1", 32'(ch_req[2]), 32'h0);
    periph_req[4] = 1'b0; tick(1);
  endtask

  task automatic t_sync_fall;
    wr(5'd2, cfgw(4, 2, 1, 0));
    periph_req[4] = 1'b1; #1;
    chk("R3 falling polarity blocks while high", 32'(ch_req[2]), 32'h0);
    sync_in[1] = 1'b0;
    tick(2);
    chk("R3 falling edge opens", 32'(ch_req[2]), 32'h1);
    tick(1);
    periph_req[4] = 1'b0;
    tick(1);
    periph_req[4] = 1'b1; #1;
    chk("R4 N=0 passes one request", 32'(ch_req[2]), 32'h0);
    periph_req[4] = 1'b0; tick(1);
  endtask

  task automatic t_overrun;
    wr(5'd6, cfgw(5, 3, 2, 2));
    sync_in[2] = 1'b1;
    tick(2);
    sync_in[2] = 1'b0;
    tick(2);
    chk("R5 overrun flag on early edge", 32'(sync_ovr), 32'h0040);
    periph_req[5] = 1'b1; #1;
    chk("R3 both-edge polarity opens", 32'(ch_req[6]), 32'h1);
    periph_req[5] = 1'b0;
    reg_addr = 5'd20; #1;
    chk("R5 overrun readback", reg_rdata, 32'h0000_0040);
    wr(5'd20, 32'h1);
    chk("R6 write 0 keeps flag", 32'(sync_ovr), 32'h0040);
    wr(5'd20, 32'h40);
    chk("R6 write 1 clears flag", 32'(sync_ovr), 32'h0);
  endtask

  task automatic t_cfg_reset;
    wr(5'd6, cfgw(5, 3, 2, 2));
    periph_req[5] = 1'b1; #1;
    chk("R7 config write closes gate", 32'(ch_req[6]), 32'h0);
    periph_req[5] = 1'b0;
    sync_in[2] = 1'b1;
    tick(2);
    chk("R7 no overrun after config write", 32'(sync_ovr), 32'h0);
    sync_in[2] = 1'b0; tick(3);
    wr(5'd6, 32'h0);
  endtask

  task automatic t_gen_sw;
    int pulses;
    wr(5'd16, gcfg(0, 0, 2));
    wr(5'd7, cfgw(21, 0, 0, 0));
    chk("R8 generator idle", 32'(ch_req[7]), 32'h0);
    wr(5'd21, 32'h1);
    chk("R8 software fire", 32'(ch_req[7]), 32'h1);
    tick(3);
    chk("R8 held until ack", 32'(ch_req[7]), 32'h1);
    wr(5'd21, 32'h1);
    pulses = 1;
    for (int k = 0; k < 4; k++) begin
      gen_ack[0] = 1'b1;
      tick(1);
      gen_ack[0] = 1'b0;
      chk("R8 dropped after ack", 32'(ch_req[7]), 32'h0);
      tick(1);
      if (ch_req[7]) pulses++;
    end
    chk("R8 N+1 pulses, busy fire ignored", 32'(pulses), 32'd3);
  endtask

  task automatic t_gen_trig;
    wr(5'd17, gcfg(3, 1, 0));
    wr(5'd8, cfgw(22, 0, 0, 0));
    trig_in[3] = 1'b1;
    tick(1);
    chk("R9 not yet after one edge", 32'(ch_req[8]), 32'h0);
    tick(1);
    chk("R9 trigger edge fires", 32'(ch_req[8]), 32'h1);
    gen_ack[1] = 1'b1;
    tick(1);
    gen_ack[1] = 1'b0;
    tick(1);
    chk("R9 single pulse for N=0", 32'(ch_req[8]), 32'h0);
    trig_in[3] = 1'b0;
    tick(3);
    chk("R9 falling trigger ignored", 32'(ch_req[8]), 32'h0);
    wr(5'd18, gcfg(4, 0, 0));
    wr(5'd9, cfgw(23, 0, 0, 0));
    trig_in[4] = 1'b1;
    tick(3);
    chk("R9 polarity 00 ignores trigger", 32'(ch_req[9]), 32'h0);
    trig_in[4] = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_route();
    t_sync_rise();
    t_sync_fall();
    t_overrun();
    t_cfg_reset();
    t_gen_sw();
    t_gen_trig();
    tick(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule